// File: doc/BRIEF.md
# Bidirectional Row Scan Shift Register

This block is the row-select side of a matrix panel driver. A chain of stages holds a scan token. The token moves one row on each shift strobe, and a direction input sets whether it moves toward the highest row or toward row 1. One row is selected at a time while the token walks the panel. Each row output carries a two-bit drive code. That code is built from the row's stage bit and the frame polarity input, and blanking forces it to deselect.

For split panels, a mode input cuts the chain into two equal halves. The lower half takes its serial data from whichever end pin is the input in the current direction. The upper half takes its serial data from a dedicated dual-mode input. The two end pins swap between serial input and serial output when the direction changes, so several devices can be cascaded in either scan direction. An active-low blanking input clears every stage and deselects all rows.

All logic runs on `clk_i`. `shift_i` is a one-cycle strobe taken at the rising edge; it stands for the falling edge of the panel's line clock.

Top module: `row_scan_shifter`

## Requirements
- R1: After `rst_ni` is deasserted, every stage is 0, so every row code is 2'b01 (non-select) while `blank_ni` is high.
- R2: In single mode (`dual_i`=0) with `dir_right_i`=1, each strobe moves every stage bit from row i to row i+1, and row 1 (index 0) loads `eio1_i`.
- R3: In single mode with `dir_right_i`=0, each strobe moves every stage bit from row i+1 to row i, and the last row (index N_ROWS-1) loads `eio2_i`.
- R4: `eio2_oe_o` equals `dir_right_i` and `eio1_oe_o` is its inverse, so exactly one end pin drives at any time.
- R5: `eio2_o` shows the last row's stage when the direction is right. `eio1_o` shows row 1's stage when the direction is left. The end pin that is not driving outputs 0.
- R6: In dual mode with the direction right, row 1 loads `eio1_i`, and row HALF+1 (index HALF) loads `dual_din_i`. The bit in row HALF does not pass into row HALF+1.
- R7: In dual mode with the direction left, row HALF (index HALF-1) loads `eio2_i`, and the last row loads `dual_din_i`. The bit in row HALF+1 does not pass into row HALF.
- R8: While `blank_ni` is high, a row's code is 2'b01 if its stage is 0. If its stage is 1, the code is 2'b10 when `frame_inv_i`=0 and 2'b11 when `frame_inv_i`=1. Row i's code is bits [2i+1:2i] of `row_code_o`.
- R9: While `blank_ni` is low, every row code is 2'b00 in the same cycle. At the next clock edge every stage is cleared, whatever `shift_i` is.
- R10: Without a strobe, all stages keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Shift strobe, one per row period |
| dir_right_i | input | 1 | 1: shift toward the last row, 0: shift toward row 1 |
| dual_i | input | 1 | 1: two independent half chains |
| blank_ni | input | 1 | Blanking, active low |
| frame_inv_i | input | 1 | Frame polarity for select codes |
| eio1_i | input | 1 | Row-1-side end pin, input value |
| eio1_o | output | 1 | Row-1-side end pin, output value |
| eio1_oe_o | output | 1 | Row-1-side end pin drives |
| eio2_i | input | 1 | Last-row-side end pin, input value |
| eio2_o | output | 1 | Last-row-side end pin, output value |
| eio2_oe_o | output | 1 | Last-row-side end pin drives |
| dual_din_i | input | 1 | Serial input of the upper half in dual mode |
| row_code_o | output | 2*N_ROWS | Per-row drive code |

## Verification
A stage update happens at the first rising edge that samples the strobe. It is visible on `row_code_o` and on the serial output pins immediately after that edge, because the stages feed the outputs through logic only. Blanking, frame polarity and the pin-enable results are combinational, so they are due within the same cycle as their input. The bench drives every input at the falling edge and compares one time unit after the rising edge. The blanking check is also sampled before the edge, which shows the deselect comes ahead of the register clear. The expected image comes from a per-row model that the bench updates by the requirements at the same edge.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic [1:0] {
    CODE_DESEL = 2'b00,
    CODE_NSEL  = 2'b01,
    CODE_SEL_P = 2'b10,
    CODE_SEL_N = 2'b11
  } row_code_e;

  function automatic row_code_e encode_row(logic on_n, logic stage, logic inv);
    if (!on_n)      return CODE_DESEL;
    else if (!stage) return CODE_NSEL;
    else if (inv)   return CODE_SEL_N;
    else            return CODE_SEL_P;
  endfunction
endpackage

// File: rtl/scan_half.sv
module scan_half #(
  parameter int LEN = 120
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           shift_i,
  input  logic           dir_right_i,
  input  logic           ser_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= '0;
    else if (shift_i) q_q <= dir_right_i ? {q_q[LEN-2:0], ser_i} : {ser_i, q_q[LEN-1:1]};
  end

  assign q_o = q_q;
endmodule

// File: rtl/row_encoder.sv
module row_encoder
  import row_scan_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic [ROWS-1:0]   stage_i,
  input  logic              blank_ni,
  input  logic              frame_inv_i,
  output logic [2*ROWS-1:0] code_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    row_code_e c;
    assign c = encode_row(blank_ni, stage_i[r], frame_inv_i);
    assign code_o[2*r +: 2] = c;
  end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
  parameter int N_ROWS = 240  // must be even
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                dir_right_i,
  input  logic                dual_i,
  input  logic                blank_ni,
  input  logic                frame_inv_i,
  input  logic                eio1_i,
  output logic                eio1_o,
  output logic                eio1_oe_o,
  input  logic                eio2_i,
  output logic                eio2_o,
  output logic                eio2_oe_o,
  input  logic                dual_din_i,
  output logic [2*N_ROWS-1:0] row_code_o
);
  localparam int HALF = N_ROWS / 2;

  logic [HALF-1:0]   q_lo, q_hi;
  logic [N_ROWS-1:0] stages;
  logic              lo_in, hi_in, clr;

  assign clr = ~blank_ni;

  // single mode: halves chained; dual mode: halves fed separately
  always_comb begin
    if (dual_i) begin
      lo_in = dir_right_i ? eio1_i : eio2_i;
      hi_in = dual_din_i;
    end else begin
      lo_in = dir_right_i ? eio1_i : q_hi[0];
      hi_in = dir_right_i ? q_lo[HALF-1] : eio2_i;
    end
  end

  scan_half #(.LEN(HALF)) u_lo (
    .clk_i, .rst_ni, .clr_i(clr), .shift_i, .dir_right_i,
    .ser_i(lo_in), .q_o(q_lo)
  );

  scan_half #(.LEN(HALF)) u_hi (
    .clk_i, .rst_ni, .clr_i(clr), .shift_i, .dir_right_i,
    .ser_i(hi_in), .q_o(q_hi)
  );

  assign stages = {q_hi, q_lo};

  row_encoder #(.ROWS(N_ROWS)) u_enc (
    .stage_i(stages), .blank_ni, .frame_inv_i, .code_o(row_code_o)
  );

  assign eio2_oe_o = dir_right_i;
  assign eio1_oe_o = ~dir_right_i;
  assign eio2_o    = dir_right_i & stages[N_ROWS-1];
  assign eio1_o    = ~dir_right_i & stages[0];
endmodule

// File: rtl/row_scan_checker.sv
module row_scan_checker #(
  parameter int N_ROWS = 240
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                shift_i,
  input logic                dir_right_i,
  input logic                dual_i,
  input logic                blank_ni,
  input logic                eio1_i,
  input logic                eio1_o,
  input logic                eio1_oe_o,
  input logic                eio2_i,
  input logic                eio2_o,
  input logic                eio2_oe_o,
  input logic                dual_din_i,
  input logic [2*N_ROWS-1:0] row_code_o
);
  localparam int HALF = N_ROWS / 2;

  assert_row1_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && dir_right_i && blank_ni) |=> (!blank_ni || row_code_o[1] == $past(eio1_i)));

  assert_last_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !dir_right_i && blank_ni) |=>
      (!blank_ni || row_code_o[2*N_ROWS-1] == $past(dual_i ? dual_din_i : eio2_i)));

  assert_pin_roles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({eio1_oe_o, eio2_oe_o}) && (eio2_oe_o == dir_right_i));

  assert_idle_pin_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eio1_oe_o || !eio2_o) && (!eio2_oe_o || !eio1_o));

  assert_boundary_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && dir_right_i && !dual_i && blank_ni) |=>
      (!blank_ni || row_code_o[2*HALF+1] == $past(row_code_o[2*HALF-1])));

  assert_boundary_dual_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && dir_right_i && dual_i && blank_ni) |=>
      (!blank_ni || row_code_o[2*HALF+1] == $past(dual_din_i)));

  assert_boundary_dual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !dir_right_i && dual_i && blank_ni) |=>
      (!blank_ni || row_code_o[2*HALF-1] == $past(eio2_i)));

  assert_blank_desel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> (row_code_o == '0));

  assert_blank_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> (!eio1_o && !eio2_o));
endmodule

bind row_scan_shifter row_scan_checker #(.N_ROWS(N_ROWS)) u_row_scan_checker (
  .clk_i, .rst_ni, .shift_i, .dir_right_i, .dual_i, .blank_ni,
  .eio1_i, .eio1_o, .eio1_oe_o, .eio2_i, .eio2_o, .eio2_oe_o,
  .dual_din_i, .row_code_o
);

// File: tb/row_scan_shifter_bench.sv
module row_scan_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 240;
  localparam int H = N / 2;

  typedef struct packed {
    logic sh, dr, du, e1, e2, dd, inv;
  } vec_t;

  // sh dr du e1 e2 dd inv
  localparam vec_t VECS [16] = '{
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic shift = 0, dir_r = 1, dual = 0, blank_n = 1, finv = 0;
  logic e1 = 0, e2 = 0, dd = 0;
  logic e1_o, e1_oe, e2_o, e2_oe;
  logic [2*N-1:0] codes;

  logic model [N];
  int   n_checks = 0, n_errors = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_scan_shifter #(.N_ROWS(N)) u_row_scan_shifter (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .dir_right_i(dir_r),
    .dual_i(dual), .blank_ni(blank_n), .frame_inv_i(finv),
    .eio1_i(e1), .eio1_o(e1_o), .eio1_oe_o(e1_oe),
    .eio2_i(e2), .eio2_o(e2_o), .eio2_oe_o(e2_oe),
    .dual_din_i(dd), .row_code_o(codes)
  );

  function automatic logic [1:0] exp_code(int r);
    if (!blank_n) return 2'b00;
    if (!model[r]) return 2'b01;
    return finv ? 2'b11 : 2'b10;
  endfunction

  task automatic check_rows(string tag);
    int bad = -1;
    n_checks++;
    for (int r = N - 1; r >= 0; r--) if (codes[2*r +: 2] !== exp_code(r)) bad = r;
    if (bad >= 0) begin
      n_errors++;
      $display("FAIL %s row index %0d code actual=%b expected=%b", tag, bad,
               codes[2*bad +: 2], exp_code(bad));
    end
  endtask

  task automatic check_pins(string tag);
    logic [3:0] act, exp;
    n_checks++;
    act = {e1_o, e1_oe, e2_o, e2_oe};
    exp = {~dir_r & model[0], ~dir_r, dir_r & model[N-1], dir_r};
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s pins {e1_o,e1_oe,e2_o,e2_oe} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_shift();
    logic nxt [N];
    for (int r = 0; r < N; r++) nxt[r] = model[r];
    if (dir_r) begin
      for (int r = 1; r < N; r++) nxt[r] = model[r-1];
      nxt[0] = e1;
      if (dual) nxt[H] = dd;
    end else begin
      for (int r = 0; r < N - 1; r++) nxt[r] = model[r+1];
      nxt[N-1] = dual ? dd : e2;
      if (dual) nxt[H-1] = e2;
    end
    for (int r = 0; r < N; r++) model[r] = nxt[r];
  endtask

  task automatic step(vec_t v, logic bl, string tag);
    @(negedge clk);
    shift = v.sh; dir_r = v.dr; dual = v.du; e1 = v.e1; e2 = v.e2; dd = v.dd;
    finv = v.inv; blank_n = bl;
    @(posedge clk);
    if (!bl) for (int r = 0; r < N; r++) model[r] = 1'b0;
    else if (v.sh) model_shift();
    #1;
    check_rows(tag);
    check_pins({tag, " R4 R5"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    string tag;
    for (int r = 0; r < N; r++) model[r] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_rows("R1 reset");
    check_pins("R1 reset R4 R5");

    // table walk
    for (int i = 0; i < 16; i++) begin
      if (!VECS[i].sh)      tag = "R10 hold";
      else if (VECS[i].du)  tag = VECS[i].dr ? "R6 dual right" : "R7 dual left";
      else                  tag = VECS[i].dr ? "R2 right" : "R3 left";
      step(VECS[i], 1'b1, tag);
    end

    // R9: deselect in the same cycle, before the edge
    @(negedge clk);
    blank_n = 1'b0; shift = 1'b1; e1 = 1'b1; e2 = 1'b1;
    #1;
    n_checks++;
    if (codes !== '0) begin
      n_errors++;
      $display("FAIL R9 immediate deselect actual=%h expected=0", codes);
    end
    step('{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, 1'b0, "R9 blank with strobe");
    step('{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, 1'b1, "R9 cleared R10");

    // R2/R5: fill the single chain rightward until data reaches eio2
    for (int i = 0; i < N + 3; i++)
      step('{1'b1,1'b1,1'b0,(i % 7 == 0),1'b0,1'b0,1'b0}, 1'b1, "R2 long right");
    // R8: polarity toggles with no strobe
    step('{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1}, 1'b1, "R8 inverted");
    step('{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, 1'b1, "R8 normal");
    // R3/R5: walk back leftward to eio1
    for (int i = 0; i < N + 3; i++)
      step('{1'b1,1'b0,1'b0,1'b0,(i % 5 == 1),1'b0,1'b0}, 1'b1, "R3 long left");
    // R6/R7: dual halves isolated at the boundary
    for (int i = 0; i < H + 2; i++)
      step('{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0}, 1'b1, "R6 halves isolated");
    for (int i = 0; i < H + 2; i++)
      step('{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0}, 1'b1, "R7 halves isolated");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule